// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM. The RAM has 17 address bits and a byte-wide data bus. It is selected by a pair of chip enables of opposite polarity, and it has an active-low output enable and an active-low write enable. The host hands over one word at a time through a valid/ready handshake. For each request the controller holds the address and produces a strobe sequence. Every strobe is registered, and every strobe length is a whole number of clock cycles.

Each strobe length comes from a nanosecond figure for the RAM. The controller divides that figure by the clock period and rounds up, with a floor of one cycle. The write pulse covers the minimum overlap of enables and write enable, the data setup before write end, and the minimum write cycle. A read holds output enable low for the full access time. After the read, the RAM gets a turnaround window to float its pins before the controller may drive the bus again. Output enable stays high through every write, so the two drivers never fight.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is low, ram_ce_n is 1, ram_ce is 0, ram_oe_n is 1, ram_we_n is 1, ram_dq_oe is 0 and req_ready is 0.
- R2: From the first clock after reset, the RAM stays selected (ram_ce_n=0, ram_ce=1). When no request is in progress, ram_oe_n=1, ram_we_n=1, ram_dq_oe=0 and req_ready=1.
- R3: A read (req_write=0) accepted at a clock edge drives ram_oe_n low from that edge for NRD = ceil(30 ns / period) cycles, which is 6 at 5 ns. ram_we_n stays 1 and ram_addr holds the accepted address the whole time.
- R4: The bus value present in the last cycle of the read access is registered into rd_data. rd_valid is high for exactly the one cycle that follows.
- R5: After every read, ram_oe_n is high for NTA = ceil(15 ns / period) turnaround cycles (3 at 5 ns). During those cycles ram_dq_oe stays 0 and req_ready stays 0.
- R6: A write (req_write=1) drives ram_we_n low from the accepting edge for NWP cycles. NWP is the largest of ceil(22 ns), ceil(18 ns) and ceil(30 ns) over the period, which is 6 at 5 ns. Throughout the pulse, ram_oe_n is 1, ram_dq_oe is 1, ram_dq_o carries the accepted data and ram_addr the accepted address.
- R7: The controller keeps driving the bus for exactly one cycle after ram_we_n returns high, then releases it (ram_dq_oe=0).
- R8: req_ready falls at the edge that accepts a request and stays low until the cycle, including any turnaround, has ended. Request inputs presented while req_ready is 0 have no effect.
- R9: The controller never drives the bus while ram_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | 8 | Read result |
| ram_addr | output | 17 | RAM address pins |
| ram_ce_n | output | 1 | RAM active-low chip enable |
| ram_ce | output | 1 | RAM active-high chip enable |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq_o | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable of the controller's bus driver |
| ram_dq_i | input | 8 | Data from the RAM bus |

## Verification
The hardest case to reach from the ports is a request that shows up while the controller is still busy. Such a request must leave no trace, either on the strobes or in the RAM contents. The bench raises req_valid with a write to an unused address in the middle of a read access and its turnaround, then withdraws it before ready returns. A later read of that address must return the old contents. The bench also places a request on the very first cycle after reset, and runs a write followed immediately by a read of the same address, so that read data depends on the data the controller drove during the write pulse.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_TURN = 3'd2,
      ST_WP   = 3'd3,
      ST_REC  = 3'd4
   } cyc_state_t;

   // whole clock cycles covering a nanosecond figure, never fewer than one
   function automatic int ns_to_cyc(input int ns, input int period);
      int c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_cyc_datapath.sv
module sram_cyc_datapath #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] bus_in,
   output logic [ADDR_W-1:0] hold_addr,
   output logic [DATA_W-1:0] hold_wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_addr  <= '0;
         hold_wdata <= '0;
      end else if (accept) begin
         hold_addr  <= in_addr;
         hold_wdata <= in_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= capture;
         if (capture)
            rdata <= bus_in;
      end
   end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_cyc_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 5,
   parameter int T_WPULSE_NS   = 22,
   parameter int T_DSETUP_NS   = 18,
   parameter int T_WCYC_NS     = 30,
   parameter int T_ACCESS_NS   = 30,
   parameter int T_RELEASE_NS  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_ce_n,
   output logic              ram_ce,
   output logic              ram_oe_n,
   output logic              ram_we_n,
   output logic [DATA_W-1:0] ram_dq_o,
   output logic              ram_dq_oe,
   input  logic [DATA_W-1:0] ram_dq_i
);
   localparam int N_WP  = max3(ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                               ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS),
                               ns_to_cyc(T_WCYC_NS, CLK_PERIOD_NS));
   localparam int N_RD  = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);
   localparam int N_TA  = ns_to_cyc(T_RELEASE_NS, CLK_PERIOD_NS);
   localparam int N_MAX = max3(N_WP, N_RD, N_TA);
   localparam int CNT_W = (N_MAX < 2) ? 1 : $clog2(N_MAX);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_cycle_ctrl: widths must be positive");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("sram_cycle_ctrl: clock period must be at least 1 ns");
      end
      if (T_DSETUP_NS > T_WPULSE_NS && N_WP < ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS)) begin : g_bad_setup
         $error("sram_cycle_ctrl: write pulse shorter than data setup");
      end
   endgenerate

   cyc_state_t st_q, st_nxt;
   logic       sel_q;
   logic       accept, tmr_zero, tmr_load, capture;
   logic [CNT_W-1:0] tmr_val;
   logic       oe_n_q, we_n_q, dq_oe_q;

   assign req_ready = sel_q && (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign capture   = (st_q == ST_RD) && tmr_zero;

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         ST_IDLE: if (accept) st_nxt = req_write ? ST_WP : ST_RD;
         ST_RD:   if (tmr_zero) st_nxt = ST_TURN;
         ST_TURN: if (tmr_zero) st_nxt = ST_IDLE;
         ST_WP:   if (tmr_zero) st_nxt = ST_REC;
         ST_REC:  st_nxt = ST_IDLE;
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (accept) begin
         tmr_load = 1'b1;
         tmr_val  = req_write ? CNT_W'(N_WP - 1) : CNT_W'(N_RD - 1);
      end else if (capture) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(N_TA - 1);
      end
   end

   // strobes come straight from flops so the RAM never sees decode glitches
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         sel_q   <= 1'b0;
         oe_n_q  <= 1'b1;
         we_n_q  <= 1'b1;
         dq_oe_q <= 1'b0;
      end else begin
         st_q    <= st_nxt;
         sel_q   <= 1'b1;
         oe_n_q  <= (st_nxt != ST_RD);
         we_n_q  <= (st_nxt != ST_WP);
         dq_oe_q <= (st_nxt == ST_WP) || (st_nxt == ST_REC);
      end
   end

   sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sram_cyc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .in_addr    (req_addr),
      .in_wdata   (req_wdata),
      .capture    (capture),
      .bus_in     (ram_dq_i),
      .hold_addr  (ram_addr),
      .hold_wdata (ram_dq_o),
      .rdata      (rd_data),
      .rvalid     (rd_valid)
   );

   assign ram_ce_n  = ~sel_q;
   assign ram_ce    = sel_q;
   assign ram_oe_n  = oe_n_q;
   assign ram_we_n  = we_n_q;
   assign ram_dq_oe = dq_oe_q;

   // R6: during the write pulse output enable is high and our driver is on
   a_r6_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (ram_oe_n && ram_dq_oe));
   // R9: no bus fight
   a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      ram_dq_oe |-> ram_oe_n);
   // R4: read valid is a single-cycle pulse
   a_r4_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   // R7: driver dropped one cycle after write enable rises
   a_r7_drv_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we_n) |=> !ram_dq_oe);
   // R8: acceptance takes ready away
   a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R3: address stays put while output enable is low
   a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_oe_n && $past(!ram_oe_n)) |-> $stable(ram_addr));
   // R5: turnaround begins with driver off and host held off
   a_r5_turn_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_oe_n) |-> (!ram_dq_oe && !req_ready));
endmodule

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/100ps
module test_sram_cycle_ctrl;
   localparam int NWP = 6;
   localparam int NRD = 6;
   localparam int NTA = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid;
   logic [7:0]  rd_data;
   logic [16:0] ram_addr;
   logic        ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_dq_oe;
   logic [7:0]  ram_dq_o, ram_dq_i;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sram_cycle_ctrl i_sram_cycle_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .ram_addr(ram_addr),
      .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_oe_n(ram_oe_n),
      .ram_we_n(ram_we_n), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe),
      .ram_dq_i(ram_dq_i)
   );

   // behavioural RAM, low 8 address bits
   logic [7:0] ram_mem [256];
   logic [7:0] shadow  [256];
   initial for (int i = 0; i < 256; i++) begin ram_mem[i] = 8'h00; shadow[i] = 8'h00; end

   always_comb
      ram_dq_i = (!ram_oe_n && ram_we_n && !ram_ce_n && ram_ce) ? ram_mem[ram_addr[7:0]] : 8'h00;

   always @(posedge ram_we_n)
      if (ram_dq_oe === 1'b1 && ram_ce === 1'b1 && ram_ce_n === 1'b0)
         ram_mem[ram_addr[7:0]] = ram_dq_o;

   // reference model: 0 idle, 1 read access, 2 turnaround, 3 write pulse, 4 recovery
   int         m_ph = 0, m_cnt = 0;
   bit         m_sel = 0, m_rv = 0, m_seen_clk = 0;
   logic [16:0] m_addr = '0;
   logic [7:0]  m_wd = '0, m_rd = '0;

   always @(posedge clk) begin
      m_seen_clk = 1;
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_sel = 0; m_rv = 0;
      end else begin
         m_rv = 0;
         case (m_ph)
            0: if (m_sel && req_valid) begin
                  m_addr = req_addr; m_wd = req_wdata;
                  if (req_write) begin m_ph = 3; m_cnt = NWP; end
                  else begin m_ph = 1; m_cnt = NRD; end
               end
            1: if (m_cnt == 1) begin
                  m_rd = shadow[m_addr[7:0]]; m_rv = 1; m_ph = 2; m_cnt = NTA;
               end else m_cnt--;
            2: if (m_cnt == 1) m_ph = 0; else m_cnt--;
            3: if (m_cnt == 1) begin shadow[m_addr[7:0]] = m_wd; m_ph = 4; end
               else m_cnt--;
            4: m_ph = 0;
            default: m_ph = 0;
         endcase
         m_sel = 1;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s at %0t: actual=%0h expected=%0h", req, what, $time, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (m_seen_clk) begin
         if (!rst_n) begin
            chk("R1", "ram_ce_n", 32'(ram_ce_n), 1);
            chk("R1", "ram_ce", 32'(ram_ce), 0);
            chk("R1", "ram_oe_n", 32'(ram_oe_n), 1);
            chk("R1", "ram_we_n", 32'(ram_we_n), 1);
            chk("R1", "ram_dq_oe", 32'(ram_dq_oe), 0);
            chk("R1", "req_ready", 32'(req_ready), 0);
         end else begin
            chk("R2", "ram_ce_n", 32'(ram_ce_n), 32'(!m_sel));
            chk("R2", "ram_ce", 32'(ram_ce), 32'(m_sel));
            chk(m_ph == 0 ? "R2" : "R8", "req_ready", 32'(req_ready), 32'(m_sel && m_ph == 0));
            chk(m_ph == 2 ? "R5" : "R3", "ram_oe_n", 32'(ram_oe_n), 32'(m_ph != 1));
            chk("R6", "ram_we_n", 32'(ram_we_n), 32'(m_ph != 3));
            chk(m_ph == 4 ? "R7" : "R6", "ram_dq_oe", 32'(ram_dq_oe), 32'(m_ph == 3 || m_ph == 4));
            chk("R9", "oe_vs_drive", 32'(ram_dq_oe && !ram_oe_n), 0);
            chk("R4", "rd_valid", 32'(rd_valid), 32'(m_rv));
            if (m_rv) chk("R4", "rd_data", 32'(rd_data), 32'(m_rd));
            if (m_ph == 3) chk("R6", "ram_dq_o", 32'(ram_dq_o), 32'(m_wd));
            if (m_ph != 0) chk("R3", "ram_addr", 32'(ram_addr), 32'(m_addr));
         end
      end
   end

   task automatic do_req(input bit wr, input logic [16:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (req_ready !== 1'b1) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (req_ready !== 1'b1) @(negedge clk);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 checked during reset; request already waiting when reset drops (R2/R8)
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h1_0011; req_wdata = 8'hA5;
      rst_n = 1'b1;
      while (req_ready !== 1'b1) @(negedge clk);
      @(negedge clk); req_valid = 1'b0;
      while (req_ready !== 1'b1) @(negedge clk);
      // R6/R3/R4: write then read back immediately, same address
      do_req(1'b1, 17'h0_0022, 8'h3C);
      do_req(1'b0, 17'h0_0022, 8'h00);
      do_req(1'b0, 17'h1_0011, 8'h00);
      // several patterns
      for (int k = 0; k < 6; k++)
         do_req(1'b1, 17'(17'h0_0040 + k * 17'h0_1003), 8'(8'h11 * k + 8'h07));
      for (int k = 5; k >= 0; k--)
         do_req(1'b0, 17'(17'h0_0040 + k * 17'h0_1003), 8'hFF);
      // R8: a request raised mid-read and withdrawn before ready returns is ignored
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h0_0022;
      @(negedge clk);
      req_write = 1'b1; req_addr = 17'h0_00EE; req_wdata = 8'h99;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
      while (req_ready !== 1'b1) @(negedge clk);
      do_req(1'b0, 17'h0_00EE, 8'h00);   // must read 00
      // back-to-back reads and writes with held valid
      do_req(1'b0, 17'h0_0000, 8'h00);
      do_req(1'b1, 17'h1_FFFF, 8'hFF);
      do_req(1'b0, 17'h1_FFFF, 8'h00);
      repeat (5) @(negedge clk);
      summary();
   end
endmodule